// File: doc/BRIEF.md
# Prioritized vectored interrupt controller

This block gathers interrupt requests for a small 8-bit processor core and presents the single most urgent one as a 16-bit vector address. Requests come from several kinds of input. Six asynchronous pins have a per-pin choice of active edge. Single-cycle strobes come from the timers, the serial port and the converter. A group of key lines fires when the group's combined level drops. A trigger pin shares one slot with the converter strobe. A software-break strobe completes the set.

Each source has a request bit and an enable bit, and one global disable flag gates every maskable source. Software reaches these through a small byte-wide register port. It can set or clear enables, and it can clear requests but never set them.

When the core pulses `ack`, the block does two things at the same clock edge: it clears the winning request and it raises the disable flag. After reset a reset slot of highest priority is pending until it is acknowledged.

Top module: `irq_vec_ctrl`

Register map (byte addresses on `bus_addr`):

| Address | Contents |
|---|---|
| 0 | Requests of sources 0..7 |
| 1 | Requests of sources 8..15 |
| 2 | Enables of sources 0..7 |
| 3 | Enables of sources 8..15 |
| 4 | Edge choice, bits 0..5 |
| 5 | Bit 0 selects the shared-slot input, bit 1 is the disable flag |

Edge choice bits 0..3 belong to `pin_ext[0..3]` and bits 4..5 to `pin_cnt[0..1]`. A 1 selects the rising edge and a 0 the falling edge.

Source index (level = index + 1, level 0 = reset):

| Index | Source |
|---|---|
| 0 | `pin_ext[0]` |
| 1 | `pin_ext[1]` |
| 2..7 | `stb_periph[0..5]` |
| 8 | `pin_cnt[0]` |
| 9 | `pin_cnt[1]` |
| 10 | `stb_periph[6]` |
| 11 | `pin_ext[2]` |
| 12 | `pin_ext[3]` |
| 13 | key group |
| 14 | shared slot |
| 15 | break |

## Requirements
- R1: After reset, requests, enables and the edge register read 0 and the control register reads 0x02. `irq` is 1 with `vec` 0xFFFC, because the reset slot is pending. One `ack` clears the reset slot.
- R2: `vec` equals 0xFFFC minus twice the level of the winning source, so it runs from 0xFFFA for index 0 down to 0xFFDC for break. `vec` is 0 while `irq` is 0.
- R3: A maskable source (index 0..14) raises `irq` only while its request bit is 1, its enable bit is 1 and the disable flag is 0.
- R4: When several sources are eligible, the one with the lowest level wins.
- R5: A write to a request byte clears each bit written 0 and leaves each bit written 1 unchanged, so software can never set a request.
- R6: A pending break request (index 15) raises `irq` whatever the disable flag and the enable bits hold.
- R7: An `ack` while `irq` is 1 clears the winning request and sets the disable flag at the same edge.
- R8: Each pin in `pin_ext` and `pin_cnt` sets its request on the edge chosen by its edge bit and ignores the other edge. The pins pass through a synchronizer, so the request is set three edges after the pin changes.
- R9: The key request is set when the AND of all `pin_key` lines falls from 1 to 0. It is set by nothing else.
- R10: With select bit 0 clear, the shared slot is set by a falling edge of `pin_trig` and ignores `stb_conv`. With the bit set, it is set by `stb_conv` and ignores `pin_trig`.
- R11: A select change can itself set a request. Changing a pin's edge bit from 1 to 0 while the pin is low sets that pin's request. Changing select bit 0 from 1 to 0 while `pin_trig` is low sets the shared-slot request.
- R12: A strobe on `stb_periph`, `stb_conv` or `stb_brk` that is high for one cycle sets its request at that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_ext | input | 4 | Asynchronous external request pins, edge selectable |
| pin_cnt | input | 2 | Asynchronous counter pins, edge selectable |
| pin_key | input | KEY_W | Asynchronous key group lines |
| pin_trig | input | 1 | Asynchronous trigger pin for the shared slot |
| stb_periph | input | 7 | Peripheral strobes: serial rx, serial tx, timers X, Y, 2, 3, 1 |
| stb_conv | input | 1 | Converter-done strobe for the shared slot |
| stb_brk | input | 1 | Software-break strobe |
| bus_we | input | 1 | Register write enable |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, one cycle after the address |
| ack | input | 1 | One-cycle acceptance from the core |
| irq | output | 1 | A source is eligible |
| vec | output | 16 | Vector address of the winning source |

## Verification
The bench walks every source in turn with all others quiet and all enables set. That ties each index to its own vector and its own clear on acknowledge, so a swapped wire or a wrong step shows up as a wrong address.

Two strobes fired in the same cycle separate the priority order from the plain decode. Masking runs with each of the enable bit and the disable flag set against the other, and break runs with both of them closed.

Opposite edges on a pin and lines of the key group falling one after another separate true edge detection from level sensing. Select changes are made with pins held high and held low, which tells a real select change that sets a request apart from one that leaves the requests alone.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC    = 16;              // maskable sources plus break
  localparam int NLVL    = NSRC + 1;        // plus the reset slot
  localparam int LVL_W   = $clog2(NLVL);
  localparam int SRC_W   = $clog2(NSRC);
  localparam int NUM_EXT = 4;
  localparam int NUM_CNT = 2;
  localparam int EDGE_W  = NUM_EXT + NUM_CNT;
  localparam int NUM_STB = 7;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 3;

  localparam int SRC_SHARED = 14;
  localparam int SRC_BRK    = 15;

  typedef enum logic [ADDR_W-1:0] {
    A_REQ_L = 3'd0,
    A_REQ_H = 3'd1,
    A_EN_L  = 3'd2,
    A_EN_H  = 3'd3,
    A_EDGE  = 3'd4,
    A_CTRL  = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic pol,   // 1: rising, 0: falling
  output logic evt
);
  logic act, act_q;

  // Polarity is applied before the history flop, so a polarity change
  // can look like an edge (intended, mirrors the select-change set).
  assign act = pol ? lvl : ~lvl;

  always_ff @(posedge clk) begin
    if (rst) act_q <= 1'b1;
    else     act_q <= act;
  end

  assign evt = act & ~act_q;
endmodule

// File: rtl/irq_req_bank.sv
module irq_req_bank
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   hw_evt,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ack,
  input  logic              irq,
  input  logic              win_rst,
  input  logic [SRC_W-1:0]  win_src,
  output logic [NSRC-1:0]   req,
  output logic [NSRC-2:0]   en_m,
  output logic              dis,
  output logic              rst_pend,
  output logic [EDGE_W-1:0] edge_sel,
  output logic              shr_sel
);
  logic [NSRC-1:0]   req_q, req_d, keep;
  logic [NSRC-1:0]   en_q;
  logic [EDGE_W-1:0] edge_q;
  logic              dis_q, shr_q, rpend_q;
  logic [DATA_W-1:0] rd_d;
  logic              take;

  assign take = ack & irq;

  always_comb begin
    keep = '1;
    if (bus_we && bus_addr == A_REQ_L) keep[DATA_W-1:0]      = bus_wdata;
    if (bus_we && bus_addr == A_REQ_H) keep[NSRC-1:DATA_W]   = bus_wdata;
    if (take && !win_rst)              keep[win_src]         = 1'b0;
    req_d = (req_q & keep) | hw_evt;   // hardware set wins over any clear
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q   <= '0;
      en_q    <= '0;
      edge_q  <= '0;
      shr_q   <= 1'b0;
      dis_q   <= 1'b1;
      rpend_q <= 1'b1;
    end else begin
      req_q <= req_d;
      if (bus_we) begin
        unique case (bus_addr)
          A_EN_L:  en_q[DATA_W-1:0]    <= bus_wdata;
          A_EN_H:  en_q[NSRC-1:DATA_W] <= bus_wdata;
          A_EDGE:  edge_q              <= bus_wdata[EDGE_W-1:0];
          A_CTRL:  begin
            shr_q <= bus_wdata[0];
            dis_q <= bus_wdata[1];
          end
          default: ;
        endcase
      end
      if (take)            dis_q   <= 1'b1;
      if (take && win_rst) rpend_q <= 1'b0;
    end
  end

  always_comb begin
    rd_d = '0;
    case (bus_addr)
      A_REQ_L: rd_d = req_q[DATA_W-1:0];
      A_REQ_H: rd_d = req_q[NSRC-1:DATA_W];
      A_EN_L:  rd_d = en_q[DATA_W-1:0];
      A_EN_H:  rd_d = en_q[NSRC-1:DATA_W];
      A_EDGE:  rd_d[EDGE_W-1:0] = edge_q;
      A_CTRL:  rd_d[1:0] = {dis_q, shr_q};
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_d;
  end

  assign req      = req_q;
  assign en_m     = en_q[NSRC-2:0];
  assign dis      = dis_q;
  assign rst_pend = rpend_q;
  assign edge_sel = edge_q;
  assign shr_sel  = shr_q;

  // R5: a register write never brings up a request bit that hardware did not set
  p_sw_no_set_r5: assert property (@(posedge clk) disable iff (rst)
    bus_we |=> ((req_q & ~$past(req_q) & ~$past(hw_evt)) == '0));

  // R7: acceptance raises the disable flag
  p_ack_dis_r7: assert property (@(posedge clk) disable iff (rst)
    (ack && irq) |=> dis_q);

  // R7: acceptance clears the winning request unless hardware re-set it
  p_ack_clr_r7: assert property (@(posedge clk) disable iff (rst)
    (ack && irq && !win_rst && !hw_evt[win_src]) |=> !req_q[$past(win_src)]);

  // R1: the reset slot only leaves through an acknowledge
  p_rst_slot_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rpend_q) |-> $past(ack));
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_pkg::*;
#(
  parameter logic [15:0] VEC_TOP = 16'hFFFC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   req,
  input  logic [NSRC-2:0]   en_m,
  input  logic              dis,
  input  logic              rst_pend,
  output logic              irq,
  output logic [15:0]       vec,
  output logic              win_rst,
  output logic [SRC_W-1:0]  win_src
);
  localparam logic [15:0] VEC_BOT = VEC_TOP - 16'(2 * (NLVL - 1));

  logic [NLVL-1:0]  live;
  logic [LVL_W-1:0] win_lvl;

  always_comb begin
    live    = '0;
    live[0] = rst_pend;
    for (int i = 0; i < NSRC - 1; i++) live[i+1] = req[i] & en_m[i] & ~dis;
    live[NLVL-1] = req[SRC_BRK];
    win_lvl = '0;
    for (int l = NLVL - 1; l >= 0; l--) begin
      if (live[l]) win_lvl = LVL_W'(l);
    end
  end

  assign irq     = |live;
  assign vec     = irq ? (VEC_TOP - 16'({win_lvl, 1'b0})) : 16'h0000;
  assign win_rst = irq && (win_lvl == '0);
  assign win_src = SRC_W'(win_lvl - LVL_W'(1));

  // R3: nothing maskable gets through while the disable flag is set
  p_mask_r3: assert property (@(posedge clk) disable iff (rst)
    (dis && !rst_pend && !req[SRC_BRK]) |-> !irq);

  // R6: break is never masked
  p_brk_r6: assert property (@(posedge clk) disable iff (rst)
    req[SRC_BRK] |-> irq);

  // R2: vector stays word aligned inside the table
  p_vec_r2: assert property (@(posedge clk) disable iff (rst)
    irq |-> (vec[0] == 1'b0 && vec <= VEC_TOP && vec >= VEC_BOT));
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_pkg::*;
#(
  parameter int          KEY_W       = 8,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] VEC_TOP     = 16'hFFFC
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_EXT-1:0]  pin_ext,
  input  logic [NUM_CNT-1:0]  pin_cnt,
  input  logic [KEY_W-1:0]    pin_key,
  input  logic                pin_trig,
  input  logic [NUM_STB-1:0]  stb_periph,
  input  logic                stb_conv,
  input  logic                stb_brk,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                ack,
  output logic                irq,
  output logic [15:0]         vec
);
  logic [EDGE_W-1:0] pins_s, pin_evt, edge_sel;
  logic [KEY_W-1:0]  key_s;
  logic              trig_s, key_evt, shr_evt, shr_lvl, shr_sel;
  logic [NSRC-1:0]   hw_evt, req;
  logic [NSRC-2:0]   en_m;
  logic              dis, rst_pend, win_rst;
  logic [SRC_W-1:0]  win_src;

  irq_sync #(.W(EDGE_W), .STAGES(SYNC_STAGES)) u_sync_pins (
    .clk(clk), .rst(rst), .d({pin_cnt, pin_ext}), .q(pins_s));
  irq_sync #(.W(KEY_W), .STAGES(SYNC_STAGES)) u_sync_key (
    .clk(clk), .rst(rst), .d(pin_key), .q(key_s));
  irq_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync_trig (
    .clk(clk), .rst(rst), .d(pin_trig), .q(trig_s));

  for (genvar g = 0; g < EDGE_W; g++) begin : g_pin
    irq_edge_det u_det (
      .clk(clk), .rst(rst), .lvl(pins_s[g]), .pol(edge_sel[g]), .evt(pin_evt[g]));
  end

  irq_edge_det u_det_key (
    .clk(clk), .rst(rst), .lvl(&key_s), .pol(1'b0), .evt(key_evt));

  // Converter strobe enters inverted so both choices fire on a falling level.
  assign shr_lvl = shr_sel ? ~stb_conv : trig_s;
  irq_edge_det u_det_shr (
    .clk(clk), .rst(rst), .lvl(shr_lvl), .pol(1'b0), .evt(shr_evt));

  assign hw_evt = {stb_brk, shr_evt, key_evt,
                   pin_evt[3], pin_evt[2], stb_periph[6],
                   pin_evt[NUM_EXT+1], pin_evt[NUM_EXT],
                   stb_periph[5:0], pin_evt[1], pin_evt[0]};

  irq_req_bank u_bank (
    .clk(clk), .rst(rst), .hw_evt(hw_evt),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ack(ack), .irq(irq), .win_rst(win_rst), .win_src(win_src),
    .req(req), .en_m(en_m), .dis(dis), .rst_pend(rst_pend),
    .edge_sel(edge_sel), .shr_sel(shr_sel));

  irq_prio_sel #(.VEC_TOP(VEC_TOP)) u_sel (
    .clk(clk), .rst(rst), .req(req), .en_m(en_m), .dis(dis), .rst_pend(rst_pend),
    .irq(irq), .vec(vec), .win_rst(win_rst), .win_src(win_src));
endmodule

// File: tb/irq_vec_ctrl_tb_top.sv
module irq_vec_ctrl_tb_top;
  localparam int KEY_W = 8;

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  pin_ext;
  logic [1:0]  pin_cnt;
  logic [KEY_W-1:0] pin_key;
  logic        pin_trig;
  logic [6:0]  stb_periph;
  logic        stb_conv, stb_brk;
  logic        bus_we;
  logic [2:0]  bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        ack, irq;
  logic [15:0] vec;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  irq_vec_ctrl #(.KEY_W(KEY_W)) dut_i (
    .clk(clk), .rst(rst), .pin_ext(pin_ext), .pin_cnt(pin_cnt), .pin_key(pin_key),
    .pin_trig(pin_trig), .stb_periph(stb_periph), .stb_conv(stb_conv), .stb_brk(stb_brk),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ack(ack), .irq(irq), .vec(vec));

  // {source index, expected vector}
  localparam logic [19:0] VT [16] = '{
    {4'd0,  16'hFFFA}, {4'd1,  16'hFFF8}, {4'd2,  16'hFFF6}, {4'd3,  16'hFFF4},
    {4'd4,  16'hFFF2}, {4'd5,  16'hFFF0}, {4'd6,  16'hFFEE}, {4'd7,  16'hFFEC},
    {4'd8,  16'hFFEA}, {4'd9,  16'hFFE8}, {4'd10, 16'hFFE6}, {4'd11, 16'hFFE4},
    {4'd12, 16'hFFE2}, {4'd13, 16'hFFE0}, {4'd14, 16'hFFDE}, {4'd15, 16'hFFDC}};

  task automatic tick(int n = 1);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    tick(2);
    d = bus_rdata;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    tick();
    ack = 1'b0;
  endtask

  task automatic clr_all();
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);
  endtask

  task automatic fire(int s);
    case (s)
      0, 1, 11, 12: begin
        int p;
        p = (s < 2) ? s : s - 9;
        pin_ext[p] = 1'b1; tick(4);
        pin_ext[p] = 1'b0; tick(4);
      end
      8, 9: begin
        pin_cnt[s-8] = 1'b1; tick(4);
        pin_cnt[s-8] = 1'b0; tick(4);
      end
      2, 3, 4, 5, 6, 7: begin
        stb_periph[s-2] = 1'b1; tick(); stb_periph = '0;
      end
      10: begin
        stb_periph[6] = 1'b1; tick(); stb_periph = '0;
      end
      13: begin
        pin_key[0] = 1'b0; tick(4);
        pin_key[0] = 1'b1; tick(4);
      end
      14: begin
        pin_trig = 1'b0; tick(4);
        pin_trig = 1'b1; tick(4);
      end
      default: begin
        stb_brk = 1'b1; tick(); stb_brk = 1'b0;
      end
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    rst = 1'b1; pin_ext = '0; pin_cnt = '0; pin_key = '1; pin_trig = 1'b1;
    stb_periph = '0; stb_conv = 1'b0; stb_brk = 1'b0;
    bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; ack = 1'b0;
    tick(4);
    rst = 1'b0;
    tick();

    // R1: reset state
    chk("R1 irq after reset", {31'd0, irq}, 32'd1);
    chk("R1 reset vector", {16'd0, vec}, 32'hFFFC);
    rd(3'd5, d); chk("R1 ctrl", {24'd0, d}, 32'h02);
    rd(3'd0, d); chk("R1 req low", {24'd0, d}, 32'h00);
    rd(3'd2, d); chk("R1 enable low", {24'd0, d}, 32'h00);
    rd(3'd4, d); chk("R1 edge", {24'd0, d}, 32'h00);
    do_ack();
    chk("R1 reset slot cleared", {31'd0, irq}, 32'd0);
    chk("R2 idle vector", {16'd0, vec}, 32'h0);

    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd4, 8'h3F);

    // R2, R7: walk every source
    for (int k = 0; k < 16; k++) begin
      clr_all();
      wr(3'd5, 8'h00);
      fire(int'(VT[k][19:16]));
      chk($sformatf("R2 irq src %0d", k), {31'd0, irq}, 32'd1);
      chk($sformatf("R2 vector src %0d", k), {16'd0, vec}, {16'd0, VT[k][15:0]});
      do_ack();
      chk($sformatf("R7 irq after ack src %0d", k), {31'd0, irq}, 32'd0);
      rd(3'd0, d); chk($sformatf("R7 req low src %0d", k), {24'd0, d}, 32'h0);
      rd(3'd1, d); chk($sformatf("R7 req high src %0d", k), {24'd0, d}, 32'h0);
      rd(3'd5, d); chk($sformatf("R7 disable set src %0d", k), {31'd0, d[1]}, 32'd1);
    end

    // R3 and R12: masking and strobe timing
    clr_all();
    wr(3'd5, 8'h00);
    wr(3'd2, 8'h00);
    stb_periph[3] = 1'b1; tick(); stb_periph = '0;
    chk("R3 disabled source", {31'd0, irq}, 32'd0);
    rd(3'd0, d); chk("R12 strobe sets request", {24'd0, d}, 32'h20);
    wr(3'd2, 8'hFF);
    chk("R3 enabled source", {31'd0, irq}, 32'd1);
    chk("R3 vector", {16'd0, vec}, 32'hFFF0);
    wr(3'd5, 8'h02);
    chk("R3 disable flag masks", {31'd0, irq}, 32'd0);

    // R4: simultaneous strobes
    clr_all();
    wr(3'd5, 8'h00);
    stb_periph = 7'b1001000; tick(); stb_periph = '0;
    chk("R4 higher wins", {16'd0, vec}, 32'hFFF0);
    do_ack();
    wr(3'd5, 8'h00);
    chk("R4 next source", {16'd0, vec}, 32'hFFE6);
    do_ack();
    chk("R4 none left", {31'd0, irq}, 32'd0);

    // R5: software cannot set
    fire(1);
    rd(3'd0, d); chk("R5 hardware set", {24'd0, d}, 32'h02);
    wr(3'd0, 8'hFF);
    rd(3'd0, d); chk("R5 write ones no effect", {24'd0, d}, 32'h02);
    wr(3'd0, 8'hFD);
    rd(3'd0, d); chk("R5 write zero clears", {24'd0, d}, 32'h00);
    wr(3'd1, 8'hFF);
    rd(3'd1, d); chk("R5 high byte stays clear", {24'd0, d}, 32'h00);

    // R6: break ignores mask
    wr(3'd3, 8'h00);
    stb_brk = 1'b1; tick(); stb_brk = 1'b0;
    chk("R6 break irq", {31'd0, irq}, 32'd1);
    chk("R6 break vector", {16'd0, vec}, 32'hFFDC);
    do_ack();
    chk("R6 break cleared", {31'd0, irq}, 32'd0);
    wr(3'd3, 8'hFF);

    // R8: edge choice
    clr_all();
    pin_ext[1] = 1'b1; tick(4);
    rd(3'd0, d); chk("R8 rising sets", {24'd0, d}, 32'h02);
    clr_all();
    pin_ext[1] = 1'b0; tick(4);
    rd(3'd0, d); chk("R8 falling ignored", {24'd0, d}, 32'h00);
    pin_cnt[1] = 1'b1; tick(4);
    wr(3'd4, 8'h1F);
    clr_all();
    tick(2);
    rd(3'd1, d); chk("R8 no set on pin high", {24'd0, d}, 32'h00);
    pin_cnt[1] = 1'b0; tick(4);
    rd(3'd1, d); chk("R8 falling sets", {24'd0, d}, 32'h02);

    // R9: key group
    clr_all();
    pin_key[2] = 1'b0; tick(4);
    rd(3'd1, d); chk("R9 key falls", {24'd0, d}, 32'h20);
    clr_all();
    pin_key[3] = 1'b0; tick(4);
    rd(3'd1, d); chk("R9 second line no set", {24'd0, d}, 32'h00);
    pin_key = '1; tick(4);
    rd(3'd1, d); chk("R9 release no set", {24'd0, d}, 32'h00);

    // R10: shared slot choice
    wr(3'd5, 8'h02);
    stb_conv = 1'b1; tick(); stb_conv = 1'b0;
    rd(3'd1, d); chk("R10 converter ignored", {24'd0, d}, 32'h00);
    wr(3'd5, 8'h03);
    tick(2);
    rd(3'd1, d); chk("R10 switch with pin high", {24'd0, d}, 32'h00);
    stb_conv = 1'b1; tick(); stb_conv = 1'b0;
    rd(3'd1, d); chk("R10 converter sets", {24'd0, d}, 32'h40);
    clr_all();
    pin_trig = 1'b0; tick(4);
    rd(3'd1, d); chk("R10 pin ignored", {24'd0, d}, 32'h00);

    // R11: select changes
    wr(3'd5, 8'h02);
    tick(2);
    rd(3'd1, d); chk("R11 shared select change", {24'd0, d}, 32'h40);
    pin_trig = 1'b1; tick(4);
    clr_all();
    wr(3'd4, 8'h1E);
    tick(2);
    rd(3'd0, d); chk("R11 edge bit change", {24'd0, d}, 32'h01);
    clr_all();
    wr(3'd4, 8'h1F);
    tick(2);
    rd(3'd0, d); chk("R11 change toward rising", {24'd0, d}, 32'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule